// File: doc/BRIEF.md
# NAND Flash Pin Controller

This peripheral lets a processor run a raw 8-bit NAND flash device by driving its pins from software. A simple synchronous request/acknowledge port with a byte address reaches six 32-bit registers. The registers are a fixed identification word, a byte data port, a control register and three read-only views of an error-correction accumulator. The control register holds the command-latch, address-latch, chip-enable and write-protect levels, and it reports the ready/busy line of the device.

A write to the data port places a byte on the flash I/O lines and pulses the write-enable strobe low. A read from the data port pulses the read-enable strobe low and returns the byte the device presents. Each strobe lasts `STROBE_CYCLES` clocks, and the bus acknowledge waits until the strobe ends. Every byte that crosses the data port is also folded into the accumulator. The accumulator keeps a byte count, a 6-bit column parity and a line parity that is twice the counter width. Software clears it by writing the count register, usually before each block of bytes.

Top module: `nandpin_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, `nf_cle`, `nf_ale`, `nf_ce`, `nf_wp`, `nf_io_oe` and `bus_ack` are 0 and `nf_we_n`, `nf_re_n` are 1. The accumulator count, column parity and line parity read as 0.
- R2: The register index is `bus_addr[11:2]`, and `bus_addr[1:0]` are ignored. Index 0 reads the constant `ID_VALUE`.
- R3: A write to index 2 keeps only bits 3:0 and drives them to the pins: bit 0 `nf_cle`, bit 1 `nf_ale`, bit 2 `nf_ce`, bit 3 `nf_wp`. A pin level changes only in the cycle in which `bus_ack` rises for that write. A read of index 2 returns the kept bits in 3:0, bit 4 set when the device reports ready, and zeros above.
- R4: `nf_rb` (1 = ready) passes through two flops before it reaches the control read value. A read accepted at the second clock edge after a change still returns the old level.
- R5: A write to index 1 drives `bus_wdata[7:0]` on `nf_io_out` with `nf_io_oe` high, and holds `nf_we_n` low for exactly `STROBE_CYCLES` clocks. `bus_ack` arrives `STROBE_CYCLES+1` clocks after acceptance.
- R6: A read of index 1 holds `nf_re_n` low for exactly `STROBE_CYCLES` clocks and returns `nf_io_in` as sampled in the last low cycle, zero-extended. `bus_ack` arrives `STROBE_CYCLES+1` clocks after acceptance.
- R7: Any other access is acknowledged one clock after acceptance. `bus_ack` is always a single-cycle pulse and only follows a request.
- R8: Index 3 reads the number of bytes transferred through the data port in either direction since the last clear, modulo 2^`COUNT_W`.
- R9: Index 4 reads the column parity, accumulated over every byte. Bit 2j is the XOR of the byte bits whose position has bit j clear, and bit 2j+1 is the XOR of those with bit j set, for j = 0..2.
- R10: Index 5 reads the line parity. For each byte with an odd number of ones, bit 2k takes XOR with the inverse of bit k of the count before that byte, and bit 2k+1 takes XOR with bit k of that count.
- R11: A write to index 3 clears the count and both parities. `bus_err` is raised with the acknowledge when the written value is nonzero.
- R12: A read of an index of 6 or above returns 0 with `bus_err`. A write to index 0, 4, 5 or 6 and above changes nothing and raises `bus_err`.
- R13: `nf_we_n` and `nf_re_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_err | output | 1 | Access error flag, valid with `bus_ack` |
| nf_cle | output | 1 | Command latch enable level |
| nf_ale | output | 1 | Address latch enable level |
| nf_ce | output | 1 | Chip enable level as programmed |
| nf_wp | output | 1 | Write protect level as programmed |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Byte driven to the flash |
| nf_io_oe | output | 1 | Output enable for `nf_io_out` |
| nf_io_in | input | 8 | Byte presented by the flash |
| nf_rb | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
The assertions assume a requester that raises `bus_req` only while no access is in flight, keeps it high until it sees `bus_ack`, and lowers it in the cycle after the pulse. The bench drives the request from a single task that does exactly this, one access at a time. The checks also assume that `nf_io_in` is stable during a read strobe. The bench changes it only between accesses, and it changes `nf_rb` on the falling clock edge.

// File: rtl/nandpin_pkg.sv
package nandpin_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_STROBE, PH_ACK} phase_e;

  localparam int CTL_W  = 4;
  localparam int CB_CLE = 0;
  localparam int CB_ALE = 1;
  localparam int CB_CE  = 2;
  localparam int CB_WP  = 3;
endpackage

// File: rtl/nandpin_sync.sv
module nandpin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nandpin_strobe.sv
module nandpin_strobe #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic is_write,
  output logic we_n,
  output logic re_n,
  output logic last
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] left;
  logic             busy;

  assign busy = !we_n || !re_n;
  assign last = busy && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_n <= 1'b1;
      re_n <= 1'b1;
      left <= '0;
    end else if (start) begin
      we_n <= !is_write;
      re_n <= is_write;
      left <= CNT_W'(CYCLES - 1);
    end else if (last) begin
      we_n <= 1'b1;
      re_n <= 1'b1;
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/nandpin_ecc.sv
module nandpin_ecc #(
  parameter int BYTE_W  = 8,
  parameter int COUNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic [BYTE_W-1:0]      data,
  output logic [COUNT_W-1:0]     count,
  output logic [2*$clog2(BYTE_W)-1:0] cp,
  output logic [2*COUNT_W-1:0]   lp
);
  localparam int SEL_W = $clog2(BYTE_W);

  logic [2*SEL_W-1:0]   cp_next;
  logic [2*COUNT_W-1:0] lp_next;

  always_comb begin
    cp_next = cp;
    for (int j = 0; j < SEL_W; j++) begin
      for (int b = 0; b < BYTE_W; b++) begin
        if (((b >> j) & 1) != 0) cp_next[2*j+1] = cp_next[2*j+1] ^ data[b];
        else                     cp_next[2*j]   = cp_next[2*j]   ^ data[b];
      end
    end
  end

  always_comb begin
    lp_next = lp;
    if (^data) begin
      for (int k = 0; k < COUNT_W; k++) begin
        lp_next[2*k]   = lp[2*k]   ^ ~count[k];
        lp_next[2*k+1] = lp[2*k+1] ^  count[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      cp    <= '0;
      lp    <= '0;
    end else if (en) begin
      count <= count + 1'b1;
      cp    <= cp_next;
      lp    <= lp_next;
    end
  end
endmodule

// File: rtl/nandpin_ctrl.sv
module nandpin_ctrl
  import nandpin_pkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          DATA_W        = 32,
  parameter int          IO_W          = 8,
  parameter int          STROBE_CYCLES = 3,
  parameter int          COUNT_W       = 8,
  parameter logic [31:0] ID_VALUE      = 32'h4E50_C001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_ce,
  output logic              nf_wp,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [IO_W-1:0]   nf_io_out,
  output logic              nf_io_oe,
  input  logic [IO_W-1:0]   nf_io_in,
  input  logic              nf_rb
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SEL_W = $clog2(IO_W);
  localparam logic [IDX_W-1:0] I_ID   = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_DATA = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_CTL  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_CNT  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_COL  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_LINE = IDX_W'(5);

  phase_e             phase;
  logic [CTL_W-1:0]   ctl;
  logic               rd_dir;
  logic [IDX_W-1:0]   idx;
  logic               accept, to_data, strobe_last;
  logic               rb_s;
  logic               ecc_en, ecc_clr;
  logic [IO_W-1:0]    ecc_byte;
  logic [COUNT_W-1:0] ecc_cnt;
  logic [2*SEL_W-1:0] ecc_cp;
  logic [2*COUNT_W-1:0] ecc_lp;
  logic [DATA_W-1:0]  reg_rd;
  logic               reg_err;
  logic               unused_addr_bits;

  assign idx              = bus_addr[ADDR_W-1:2];
  assign unused_addr_bits = ^bus_addr[1:0];
  assign accept           = (phase == PH_IDLE) && bus_req;
  assign to_data          = (idx == I_DATA);

  nandpin_sync #(.STAGES(2)) u_rb_sync (
    .clk(clk), .rst(rst), .d(nf_rb), .q(rb_s)
  );

  nandpin_strobe #(.CYCLES(STROBE_CYCLES)) u_strobe (
    .clk(clk), .rst(rst),
    .start(accept && to_data), .is_write(bus_we),
    .we_n(nf_we_n), .re_n(nf_re_n), .last(strobe_last)
  );

  // Bytes enter the accumulator as they cross the data port
  assign ecc_en   = (accept && to_data && bus_we) ||
                    ((phase == PH_STROBE) && strobe_last && rd_dir);
  assign ecc_byte = (phase == PH_STROBE) ? nf_io_in : bus_wdata[IO_W-1:0];
  assign ecc_clr  = accept && bus_we && (idx == I_CNT);

  nandpin_ecc #(.BYTE_W(IO_W), .COUNT_W(COUNT_W)) u_ecc (
    .clk(clk), .rst(rst), .clr(ecc_clr), .en(ecc_en), .data(ecc_byte),
    .count(ecc_cnt), .cp(ecc_cp), .lp(ecc_lp)
  );

  always_comb begin
    reg_rd  = '0;
    reg_err = 1'b0;
    if (bus_we) begin
      if (idx == I_CNT)      reg_err = (bus_wdata != '0);
      else if (idx != I_CTL) reg_err = 1'b1;
    end else begin
      case (idx)
        I_ID:    reg_rd = DATA_W'(ID_VALUE);
        I_CTL:   reg_rd = DATA_W'({rb_s, ctl});
        I_CNT:   reg_rd = DATA_W'(ecc_cnt);
        I_COL:   reg_rd = DATA_W'(ecc_cp);
        I_LINE:  reg_rd = DATA_W'(ecc_lp);
        default: reg_err = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      ctl       <= '0;
      rd_dir    <= 1'b0;
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
      bus_err   <= 1'b0;
      nf_io_out <= '0;
      nf_io_oe  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            if (to_data) begin
              rd_dir <= !bus_we;
              phase  <= PH_STROBE;
              if (bus_we) begin
                nf_io_out <= bus_wdata[IO_W-1:0];
                nf_io_oe  <= 1'b1;
              end
            end else begin
              if (bus_we && idx == I_CTL) ctl <= bus_wdata[CTL_W-1:0];
              bus_rdata <= reg_rd;
              bus_err   <= reg_err;
              bus_ack   <= 1'b1;
              phase     <= PH_ACK;
            end
          end
        end
        PH_STROBE: begin
          if (strobe_last) begin
            bus_rdata <= rd_dir ? DATA_W'(nf_io_in) : '0;
            bus_err   <= 1'b0;
            bus_ack   <= 1'b1;
            phase     <= PH_ACK;
          end
        end
        default: begin
          bus_ack  <= 1'b0;
          nf_io_oe <= 1'b0;
          phase    <= PH_IDLE;
        end
      endcase
    end
  end

  assign nf_cle = ctl[CB_CLE];
  assign nf_ale = ctl[CB_ALE];
  assign nf_ce  = ctl[CB_CE];
  assign nf_wp  = ctl[CB_WP];
endmodule

// File: rtl/nandpin_ctrl_chk.sv
module nandpin_ctrl_chk #(
  parameter int STROBE_CYCLES = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       bus_ack,
  input logic       we_n,
  input logic       re_n,
  input logic       io_oe,
  input logic [3:0] pins
);
  int low_run;

  always_ff @(posedge clk) begin
    if (rst)                low_run <= 0;
    else if (!we_n || !re_n) low_run <= low_run + 1;
    else                    low_run <= 0;
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n));

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) bus_ack |=> !bus_ack);

  // R7
  ack_follows_req_chk: assert property (@(posedge clk) disable iff (rst) bus_ack |-> $past(bus_req));

  // R3
  pins_on_ack_chk: assert property (@(posedge clk) disable iff (rst) !$stable(pins) |-> bus_ack);

  // R5
  oe_with_we_chk: assert property (@(posedge clk) disable iff (rst) !we_n |-> io_oe);

  // R6
  strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
    (low_run != 0 && we_n && re_n) |-> (low_run == STROBE_CYCLES));
endmodule

bind nandpin_ctrl nandpin_ctrl_chk #(.STROBE_CYCLES(STROBE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_ack(bus_ack),
  .we_n(nf_we_n), .re_n(nf_re_n), .io_oe(nf_io_oe),
  .pins({nf_wp, nf_ce, nf_ale, nf_cle})
);

// File: tb/nandpin_ctrl_tb.sv
module nandpin_ctrl_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          NSTROBE    = 3;
  localparam logic [31:0] BID        = 32'h4E50_C001;
  localparam int          NVEC       = 14;

  // {we, addr, wdata, io_in, expected rdata, expected err}
  localparam logic [85:0] VEC [NVEC] = '{
    {1'b0, 12'h000, 32'h0,         8'h00, BID,          1'b0}, // R2 id
    {1'b0, 12'h003, 32'h0,         8'h00, BID,          1'b0}, // R2 low bits ignored
    {1'b1, 12'h008, 32'hFFFF_FFF5, 8'h00, 32'h0,        1'b0}, // R3 ctl write
    {1'b0, 12'h008, 32'h0,         8'h00, 32'h0000_0015, 1'b0}, // R3 ctl read, ready
    {1'b1, 12'h00A, 32'h0000_000A, 8'h00, 32'h0,        1'b0}, // R3
    {1'b0, 12'h008, 32'h0,         8'h00, 32'h0000_001A, 1'b0}, // R3
    {1'b0, 12'h004, 32'h0,         8'h3C, 32'h0000_003C, 1'b0}, // R6 data read
    {1'b1, 12'h004, 32'hABCD_EE5A, 8'h00, 32'h0,        1'b0}, // R5 data write
    {1'b0, 12'h018, 32'h0,         8'h00, 32'h0,        1'b1}, // R12 unmapped read
    {1'b1, 12'hFFC, 32'h0000_1234, 8'h00, 32'h0,        1'b1}, // R12 unmapped write
    {1'b1, 12'h000, 32'h0000_0055, 8'h00, 32'h0,        1'b1}, // R12 id write
    {1'b0, 12'h000, 32'h0,         8'h00, BID,          1'b0}, // R12 id unchanged
    {1'b1, 12'h00C, 32'h0,         8'h00, 32'h0,        1'b0}, // R11 clear
    {1'b0, 12'h00C, 32'h0,         8'h00, 32'h0,        1'b0}  // R11 count zero
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ack, bus_err;
  logic        nf_cle, nf_ale, nf_ce, nf_wp, nf_we_n, nf_re_n, nf_io_oe, nf_rb;
  logic [7:0]  nf_io_out, nf_io_in;

  int errors = 0;
  int checks = 0;

  int         we_cnt, re_cnt;
  logic [7:0] we_io;
  logic       oe_ok, both_low;

  logic [7:0]  m_cnt;
  logic [5:0]  m_cp;
  logic [15:0] m_lp;

  always #(CLK_PERIOD/2) clk = ~clk;

  nandpin_ctrl #(.STROBE_CYCLES(NSTROBE), .ID_VALUE(BID)) u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce(nf_ce), .nf_wp(nf_wp),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_io_out(nf_io_out),
    .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
  );

  always @(negedge clk) begin
    if (!nf_we_n) begin
      we_cnt = we_cnt + 1;
      we_io  = nf_io_out;
      if (!nf_io_oe) oe_ok = 1'b0;
    end
    if (!nf_re_n) re_cnt = re_cnt + 1;
    if (!nf_we_n && !nf_re_n) both_low = 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_byte(input logic [7:0] b);
    for (int j = 0; j < 3; j++)
      for (int i = 0; i < 8; i++)
        if (((i >> j) & 1) != 0) m_cp[2*j+1] ^= b[i];
        else                     m_cp[2*j]   ^= b[i];
    if (^b)
      for (int k = 0; k < 8; k++) begin
        m_lp[2*k]   ^= ~m_cnt[k];
        m_lp[2*k+1] ^=  m_cnt[k];
      end
    m_cnt = m_cnt + 8'd1;
  endtask

  task automatic model_clear();
    m_cnt = '0; m_cp = '0; m_lp = '0;
  endtask

  task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] wd,
                      output logic [31:0] rd, output logic er, output int lat);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ack && lat < 1000);
    rd = bus_rdata; er = bus_err;
    bus_req = 1'b0;
    @(negedge clk);
    chk(!bus_ack, "R7 ack single cycle", {31'd0, bus_ack}, 32'd0);
  endtask

  task automatic clear_mon();
    we_cnt = 0; re_cnt = 0; we_io = '0; oe_ok = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    int          lat;
    logic [85:0] v;

    both_low = 1'b0;
    clear_mon();
    model_clear();
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    nf_io_in = '0; nf_rb = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, during reset
    chk({nf_cle, nf_ale, nf_ce, nf_wp, nf_io_oe, bus_ack} == 6'b0, "R1 pins low in reset",
        {26'd0, nf_cle, nf_ale, nf_ce, nf_wp, nf_io_oe, bus_ack}, 32'd0);
    chk(nf_we_n && nf_re_n, "R1 strobes high in reset", {30'd0, nf_we_n, nf_re_n}, 32'd3);
    rst = 1'b0;
    @(negedge clk);
    chk({nf_cle, nf_ale, nf_ce, nf_wp, nf_io_oe, bus_ack} == 6'b0, "R1 pins low after reset",
        {26'd0, nf_cle, nf_ale, nf_ce, nf_wp, nf_io_oe, bus_ack}, 32'd0);
    xfer(1'b0, 12'h00C, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R1 count cleared", rd, 32'd0);
    xfer(1'b0, 12'h014, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R1 line parity cleared", rd, 32'd0);

    // Table of vectors
    for (int n = 0; n < NVEC; n++) begin
      v = VEC[n];
      nf_io_in = v[40:33];
      xfer(v[85], v[84:73], v[72:41], rd, er, lat);
      if (!v[85]) chk(rd == v[32:1], $sformatf("R2/R3/R6/R11/R12 vector %0d rdata", n), rd, v[32:1]);
      chk(er == v[0], $sformatf("R11/R12 vector %0d err", n), {31'd0, er}, {31'd0, v[0]});
    end
    chk({nf_wp, nf_ce, nf_ale, nf_cle} == 4'b1010, "R3 pins after table",
        {28'd0, nf_wp, nf_ce, nf_ale, nf_cle}, 32'hA);

    // R3 upper bits dropped, pins follow
    xfer(1'b1, 12'h008, 32'h0000_00F5, rd, er, lat);
    chk({nf_wp, nf_ce, nf_ale, nf_cle} == 4'b0101, "R3 pins 0101",
        {28'd0, nf_wp, nf_ce, nf_ale, nf_cle}, 32'h5);
    chk(lat == 1, "R7 control write latency", lat, 32'd1);

    // R5 data write strobe
    clear_mon();
    xfer(1'b1, 12'h004, 32'h1234_56C3, rd, er, lat);
    chk(we_cnt == NSTROBE, "R5 we_n low length", we_cnt, NSTROBE);
    chk(we_io == 8'hC3, "R5 io byte", {24'd0, we_io}, 32'hC3);
    chk(oe_ok, "R5 oe during strobe", {31'd0, oe_ok}, 32'd1);
    chk(re_cnt == 0, "R5 no read strobe", re_cnt, 32'd0);
    chk(lat == NSTROBE + 1, "R5 ack latency", lat, NSTROBE + 1);

    // R6 data read strobe
    clear_mon();
    nf_io_in = 8'h96;
    xfer(1'b0, 12'h004, 32'h0, rd, er, lat);
    chk(rd == 32'h96, "R6 read byte", rd, 32'h96);
    chk(re_cnt == NSTROBE, "R6 re_n low length", re_cnt, NSTROBE);
    chk(we_cnt == 0, "R6 no write strobe", we_cnt, 32'd0);
    chk(lat == NSTROBE + 1, "R6 ack latency", lat, NSTROBE + 1);

    // R4 two-flop lag on ready/busy
    nf_rb = 1'b0;
    xfer(1'b0, 12'h008, 32'h0, rd, er, lat);
    chk(rd == 32'h15, "R4 busy not yet visible", rd, 32'h15);
    xfer(1'b0, 12'h008, 32'h0, rd, er, lat);
    chk(rd == 32'h05, "R4 busy visible", rd, 32'h05);
    chk(lat == 1, "R7 control read latency", lat, 32'd1);
    nf_rb = 1'b1;

    // R8 R9 R10 mixed traffic
    xfer(1'b1, 12'h00C, 32'h0, rd, er, lat);
    model_clear();
    for (int i = 0; i < 20; i++) begin
      logic [7:0] b;
      if (i % 3 == 2) begin
        b = 8'(i * 91 + 3);
        nf_io_in = b;
        xfer(1'b0, 12'h004, 32'h0, rd, er, lat);
      end else begin
        b = 8'(i * 37 + 5);
        xfer(1'b1, 12'h004, {24'hFFFF00, b}, rd, er, lat);
      end
      model_byte(b);
    end
    xfer(1'b0, 12'h00C, 32'h0, rd, er, lat);
    chk(rd == {24'd0, m_cnt}, "R8 byte count", rd, {24'd0, m_cnt});
    xfer(1'b0, 12'h010, 32'h0, rd, er, lat);
    chk(rd == {26'd0, m_cp}, "R9 column parity", rd, {26'd0, m_cp});
    xfer(1'b0, 12'h014, 32'h0, rd, er, lat);
    chk(rd == {16'd0, m_lp}, "R10 line parity", rd, {16'd0, m_lp});

    // R8 wrap of the count
    xfer(1'b1, 12'h00C, 32'h0, rd, er, lat);
    model_clear();
    for (int i = 0; i < 257; i++) begin
      logic [7:0] b;
      b = 8'(i * 13 + 1);
      xfer(1'b1, 12'h004, {24'd0, b}, rd, er, lat);
      model_byte(b);
    end
    xfer(1'b0, 12'h00C, 32'h0, rd, er, lat);
    chk(rd == 32'd1, "R8 count wraps", rd, 32'd1);
    xfer(1'b0, 12'h014, 32'h0, rd, er, lat);
    chk(rd == {16'd0, m_lp}, "R10 line parity after wrap", rd, {16'd0, m_lp});
    xfer(1'b0, 12'h010, 32'h0, rd, er, lat);
    chk(rd == {26'd0, m_cp}, "R9 column parity after wrap", rd, {26'd0, m_cp});

    // R11 nonzero clear flags but still clears
    xfer(1'b1, 12'h00C, 32'h0000_0007, rd, er, lat);
    chk(er == 1'b1, "R11 nonzero clear err", {31'd0, er}, 32'd1);
    xfer(1'b0, 12'h00C, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R11 count cleared", rd, 32'd0);
    xfer(1'b0, 12'h010, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R11 column parity cleared", rd, 32'd0);
    xfer(1'b0, 12'h014, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R11 line parity cleared", rd, 32'd0);

    // R12 write to parity register leaves it unchanged
    xfer(1'b1, 12'h010, 32'h0000_003F, rd, er, lat);
    chk(er == 1'b1, "R12 parity write err", {31'd0, er}, 32'd1);
    xfer(1'b0, 12'h010, 32'h0, rd, er, lat);
    chk(rd == 32'd0, "R12 parity unchanged", rd, 32'd0);

    // R13 never both strobes
    chk(!both_low, "R13 strobes exclusive", {31'd0, both_low}, 32'd0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule